// File: doc/BRIEF.md
# Interrupt Vector Instruction Injector

This block sits on the peripheral side of an 8-bit processor bus. It serves one interrupt source. When the source asks for service, the block raises the processor's interrupt request line and holds the 3-bit vector the source supplied.

The block then watches each machine cycle's status byte, which the processor presents while its sync pulse is high. When it sees an interrupt-acknowledge cycle, it drops the request. During that cycle's data-bus-in strobe it stands in for memory: it places a one-byte restart call on the read path and cuts off the memory data that would otherwise reach the processor.

Outside that single strobe, memory data passes through unchanged and the injector drives nothing. The restart call sends the processor to address vector × 8.

Top module: `vec_injector`

## Requirements
- R1: After reset `int_req` is 0, `inj_oe` is 0, `mem_connect` is 1 and `rd_bus` equals `mem_rdata`.
- R2: A `src_req` high at a clock edge while the block is idle raises `int_req` from the next cycle and captures `src_vec` as the vector.
- R3: `int_req` stays high across machine cycles whose status byte is not an acknowledge (status bit 5 or bit 0 clear).
- R4: The status byte is taken at the last clock edge with `sync` high. It is decoded at the first edge with `sync` low. If bit 5 (M1) and bit 0 (acknowledge) are both 1 and a request is pending, `int_req` is 0 from the next cycle.
- R5: After an acknowledge, while `dbin` is high, `inj_oe` is 1, `mem_connect` is 0 and `rd_bus` carries the restart opcode. These three outputs follow `dbin` combinationally.
- R6: The restart opcode is binary 11NNN111, with NNN the captured vector. This selects target address NNN×8, from 0 to 56, for every vector value 0..7.
- R7: A `src_req` while a request is pending or armed is ignored: neither `int_req` nor the vector that is later driven changes.
- R8: The first clock edge with `dbin` low after the armed strobe returns the block to idle. After that, `inj_oe` is 0 and a new `src_req` is accepted.
- R9: When the block is not armed, `dbin` high leaves `inj_oe` at 0, `mem_connect` at 1 and `rd_bus` equal to `mem_rdata`.
- R10: An acknowledge status seen while no request is pending causes no drive in that cycle's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 1 | Service request from the interrupt source |
| src_vec | input | 3 | Vector number from the source |
| int_req | output | 1 | Interrupt request line to the processor |
| sync | input | 1 | Processor sync pulse marking the status interval |
| dbin | input | 1 | Processor data-bus-in strobe |
| cpu_status | input | 8 | Processor data bus as seen during sync |
| mem_rdata | input | 8 | Read data from memory |
| rd_bus | output | 8 | Read data presented to the processor |
| inj_oe | output | 1 | High while the injector owns the read path |
| mem_connect | output | 1 | High while the memory path is connected |

## Verification
The hardest state to reach is the armed state with a second request arriving. That state requires a pending request, a full machine cycle whose status carries both decoded bits, and then a strobe, all in order.

The bench models each machine cycle as a sync interval followed by a read strobe. It runs every vector through pending, non-acknowledge cycles, the acknowledge and the strobe. Along the way it injects competing requests with a different vector at the pending and armed points. Acknowledge cycles with no request pending, and status bytes carrying only one of the two bits, round out the sweep.

// File: rtl/vinj_pkg.sv
package vinj_pkg;
  localparam int BYTE_W = 8;
  localparam int VNUM_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_ARMED = 2'd2
  } vinj_state_e;

  // One-byte restart call: 11 NNN 111
  function automatic logic [BYTE_W-1:0] restart_opcode(input logic [VNUM_W-1:0] v);
    return {2'b11, v, 3'b111};
  endfunction

  function automatic logic is_ack_status(input logic [BYTE_W-1:0] s,
                                         input int m1_pos, input int ack_pos);
    return s[m1_pos] & s[ack_pos];
  endfunction
endpackage

// File: rtl/vinj_status_cap.sv
module vinj_status_cap
  import vinj_pkg::*;
#(
  parameter int M1_POS  = 5,
  parameter int ACK_POS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic [BYTE_W-1:0] cpu_status,
  output logic              ack_seen
);
  logic              sync_q;
  logic [BYTE_W-1:0] status_q;
  logic              sync_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      status_q <= '0;
    end else begin
      sync_q <= sync;
      if (sync) status_q <= cpu_status;
    end
  end

  assign sync_fall = sync_q & ~sync;
  assign ack_seen  = sync_fall & is_ack_status(status_q, M1_POS, ACK_POS);

  p_ack_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |-> ($past(sync) && !sync));
endmodule

// File: rtl/vinj_fsm.sv
module vinj_fsm
  import vinj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_req,
  input  logic [VNUM_W-1:0] src_vec,
  input  logic              ack_seen,
  input  logic              dbin,
  output logic              int_req,
  output logic              armed,
  output logic [VNUM_W-1:0] vec_q
);
  vinj_state_e state, state_nx;
  logic        dbin_q;
  logic        win_close;

  assign win_close = dbin_q & ~dbin;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (src_req)   state_nx = ST_PEND;
      ST_PEND:  if (ack_seen)  state_nx = ST_ARMED;
      ST_ARMED: if (win_close) state_nx = ST_IDLE;
      default:                 state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dbin_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      state  <= state_nx;
      dbin_q <= dbin;
      if (state == ST_IDLE && src_req) vec_q <= src_vec;
    end
  end

  assign int_req = (state == ST_PEND);
  assign armed   = (state == ST_ARMED);

  p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && src_req) |=> int_req);
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && ack_seen) |=> !int_req);
  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(vec_q));
  p_idle_after_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && win_close) |=> !armed && !int_req);
endmodule

// File: rtl/vinj_bus_mux.sv
module vinj_bus_mux
  import vinj_pkg::*;
(
  input  logic              armed,
  input  logic              dbin,
  input  logic [VNUM_W-1:0] vec,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [BYTE_W-1:0] rd_bus,
  output logic              inj_oe,
  output logic              mem_connect
);
  assign inj_oe      = armed & dbin;
  assign mem_connect = ~inj_oe;
  assign rd_bus      = inj_oe ? restart_opcode(vec) : mem_rdata;

  always_comb begin
    if (inj_oe) p_oe_needs_dbin_r5: assert (dbin);
  end
endmodule

// File: rtl/vec_injector.sv
module vec_injector
  import vinj_pkg::*;
#(
  parameter int M1_POS  = 5,
  parameter int ACK_POS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_req,
  input  logic [VNUM_W-1:0] src_vec,
  output logic              int_req,
  input  logic              sync,
  input  logic              dbin,
  input  logic [BYTE_W-1:0] cpu_status,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [BYTE_W-1:0] rd_bus,
  output logic              inj_oe,
  output logic              mem_connect
);
  logic              ack_seen;
  logic              armed;
  logic [VNUM_W-1:0] vec_q;

  vinj_status_cap #(.M1_POS(M1_POS), .ACK_POS(ACK_POS)) u_cap (
    .clk(clk), .rst_n(rst_n), .sync(sync),
    .cpu_status(cpu_status), .ack_seen(ack_seen)
  );

  vinj_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_vec(src_vec),
    .ack_seen(ack_seen), .dbin(dbin), .int_req(int_req),
    .armed(armed), .vec_q(vec_q)
  );

  vinj_bus_mux u_mux (
    .armed(armed), .dbin(dbin), .vec(vec_q), .mem_rdata(mem_rdata),
    .rd_bus(rd_bus), .inj_oe(inj_oe), .mem_connect(mem_connect)
  );

  p_arm_needs_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(armed)) |-> $past(int_req));
  p_mem_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dbin |-> (mem_connect && !inj_oe));
endmodule

// File: tb/test_vec_injector.sv
module test_vec_injector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_req = 1'b0;
  logic [2:0] src_vec = '0;
  logic       int_req;
  logic       sync = 1'b0;
  logic       dbin = 1'b0;
  logic [7:0] cpu_status = '0;
  logic [7:0] mem_rdata = 8'h5A;
  logic [7:0] rd_bus;
  logic       inj_oe;
  logic       mem_connect;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vec_injector i_vec_injector (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_vec(src_vec),
    .int_req(int_req), .sync(sync), .dbin(dbin), .cpu_status(cpu_status),
    .mem_rdata(mem_rdata), .rd_bus(rd_bus), .inj_oe(inj_oe),
    .mem_connect(mem_connect)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected restart target: address vector*8, opcode = 0xC7 + address
  function automatic int expect_op(input int v);
    return 199 + v * 8;
  endfunction

  task automatic pulse_req(input int v);
    @(negedge clk);
    src_req = 1'b1; src_vec = 3'(v);
    @(negedge clk);
    src_req = 1'b0; src_vec = 3'(7 - v);
  endtask

  // One machine cycle: sync interval with status, then a read strobe.
  task automatic mcycle(input logic [7:0] st, input bit exp_drive, input int v,
                        input bit exp_req_after, input bit late_req);
    @(negedge clk);
    sync = 1'b1; cpu_status = st;
    @(negedge clk);
    sync = 1'b0; cpu_status = 8'hFF;
    @(negedge clk);
    chk("R4 int_req after status", int'(int_req), int'(exp_req_after));
    if (late_req) begin src_req = 1'b1; src_vec = 3'(v ^ 3'b101); end
    mem_rdata = 8'(v * 17 + 3);
    dbin = 1'b1;
    #1;
    if (exp_drive) begin
      chk("R5 inj_oe", int'(inj_oe), 1);
      chk("R5 mem_connect", int'(mem_connect), 0);
      chk("R6 opcode", int'(rd_bus), expect_op(v));
    end else begin
      chk("R9 inj_oe", int'(inj_oe), 0);
      chk("R9 rd_bus pass", int'(rd_bus), int'(mem_rdata));
    end
    @(negedge clk);
    src_req = 1'b0;
    if (exp_drive) chk("R7 opcode held", int'(rd_bus), expect_op(v));
    dbin = 1'b0;
    @(negedge clk);
    chk("R8 oe off", int'(inj_oe), 0);
    chk("R8 mem path", int'(mem_connect), 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 int_req", int'(int_req), 0);
    chk("R1 inj_oe", int'(inj_oe), 0);
    chk("R1 mem_connect", int'(mem_connect), 1);
    chk("R1 rd_bus", int'(rd_bus), int'(mem_rdata));
    rst_n = 1'b1;

    // R10: acknowledge with nothing pending
    mcycle(8'h23, 1'b0, 2, 1'b0, 1'b0);

    for (int v = 0; v < 8; v++) begin
      pulse_req(v);
      chk("R2 int_req raised", int'(int_req), 1);
      // R7: competing request while pending
      pulse_req((v + 3) % 8);
      chk("R7 int_req", int'(int_req), 1);
      // R3: ordinary fetch, and one-bit-only status bytes
      mcycle(8'hA2, 1'b0, v, 1'b1, 1'b0);
      mcycle(8'h01, 1'b0, v, 1'b1, 1'b0);
      mcycle(8'h20, 1'b0, v, 1'b1, 1'b0);
      // R4/R5/R6: acknowledge; R7: late request while armed
      mcycle(8'h23, 1'b1, v, 1'b0, (v % 2) == 1);
      chk("R7 armed request ignored", int'(int_req), 0);
      // R9: next strobe passes memory data
      mcycle(8'hA2, 1'b0, v, 1'b0, 1'b0);
    end

    // R8: new request accepted after the window
    pulse_req(5);
    chk("R8 re-accept", int'(int_req), 1);
    mcycle(8'h23, 1'b1, 5, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule